// File: doc/BRIEF.md
# System Control Register Bank

This block holds the global control and status words of a chip behind a small 32-bit register interface. A requester presents a valid strobe, a write flag, a 12-bit byte address inside a 4 KiB window and write data. Only word-aligned addresses that fall on an implemented word take effect. Each word follows one of four update rules: fixed against software writes, clear-where-one, set-only, or plain overwrite. Reads return one cycle after the request on a registered data bus, with a one-cycle response strobe.

A synchronous cold reset loads fixed values into most words. It also loads three words from outside the bus: a 32-bit strap pattern, a 32-bit module-disable pattern, and a memory configuration word built from an elaboration-time memory-size code. The meaning of the bits (pin multiplexing, interrupt routing, PHY tuning) belongs to the blocks that consume them. This bank only stores them and enforces the write rules.

Top module: `sysctl_regbank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every word takes its cold value: word 0x000 = 0x04A92750, 0x018 = 0x0000FFFF, 0x038 = 0x00000003, 0x03C = 0x0000035E, 0x050 = 0x0000004E, 0x060 = 0x00080000, 0x06C = 0x80000000, 0x078 = 0x000000C0, 0x098 = 0x5A00F3CF, 0x13C = 0x00000008, 0x140 = 0x034730E4, 0x144 = 0x034730E4. Every other implemented word not named in R2 is zero.
- R2: At cold reset, word 0x004 takes `strap_pwron`, word 0x07C takes `strap_moddis`, and word 0x09C takes 0x00001002 OR (`MEM_SIZE_CODE` << 8). The code is log2(memory size / 128 MiB), and only values 0 to 4 are legal. A larger code stops elaboration.
- R3: Writes to words 0x000, 0x004 and 0x040 leave them unchanged.
- R4: A write to word 0x06C or 0x0D4 stores old AND NOT data, so each 1 in the data clears that bit and no bit is ever set.
- R5: A write to word 0x07C or 0x070 stores old OR data. Software cannot clear a set bit; only cold reset clears it.
- R6: A write to any other implemented word stores the data as given.
- R7: Implemented words span byte offsets 0x000 to 0x144, which is 82 words. A read at offset 0x148 or above returns zero, and a write there changes no word.
- R8: An address with bits 1:0 not zero is rejected. A read returns zero and a write changes no word, including the word at the aligned address below it.
- R9: Each read request gives exactly one `rsp_valid` pulse and its data in the next cycle. Write requests and idle cycles give no pulse. A read issued in the cycle right after a write to the same word returns the written result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| strap_pwron | input | 32 | Strap pattern loaded into word 0x004 at reset |
| strap_moddis | input | 32 | Module-disable pattern loaded into word 0x07C at reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe, one cycle after a read request |
| rsp_rdata | output | 32 | Read data, zero when no response |

## Verification
A word with the wrong rule or the wrong cold value is not visible until it is read. The bench therefore reads back every word after each cold reset, and after each write to a word with a special rule. A wrong value then shows on `rsp_rdata` exactly one cycle after the read request. A decode fault that lets a rejected write land on some word shows only when that word is read. For this reason the bench reads the nearby aligned word after every rejected write. A fault in the response strobe shows in the same cycle: a pulse with nothing outstanding, or a missing pulse that leaves expected items unconsumed at the end.

// File: rtl/sysctl_pkg.sv
// Shared constants and per-word tables for the system control register bank.
// Assumes a 4 KiB byte window with 32-bit words, 82 of them implemented.
package sysctl_pkg;

    localparam int DW     = 32;
    localparam int AW     = 12;
    localparam int NWORDS = 82;
    localparam int IW     = AW - 2;

    // word indices whose reset value does not come from the fixed table
    localparam int IDX_STRAP  = 1;
    localparam int IDX_MODDIS = 31;
    localparam int IDX_MEMCFG = 39;

    localparam logic [DW-1:0] MEMCFG_BASE = 32'h0000_1002;

    typedef enum logic [1:0] {
        ACC_RW  = 2'd0,
        ACC_RO  = 2'd1,
        ACC_W1C = 2'd2,
        ACC_SET = 2'd3
    } acc_e;

    // write rule of a word, by word index
    function automatic acc_e acc_of(input int idx);
        case (idx)
            0, 1, 16: return ACC_RO;
            27, 53:   return ACC_W1C;
            28, 31:   return ACC_SET;
            default:  return ACC_RW;
        endcase
    endfunction

    // fixed cold value of a word, by word index
    function automatic logic [DW-1:0] fixed_rst(input int idx);
        case (idx)
            0:       return 32'h04A9_2750;
            6:       return 32'h0000_FFFF;
            14:      return 32'h0000_0003;
            15:      return 32'h0000_035E;
            20:      return 32'h0000_004E;
            24:      return 32'h0008_0000;
            27:      return 32'h8000_0000;
            30:      return 32'h0000_00C0;
            38:      return 32'h5A00_F3CF;
            79:      return 32'h0000_0008;
            80, 81:  return 32'h0347_30E4;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Address decoder: splits a byte address into a word index and flags
// whether the access is aligned and falls on an implemented word.
// Assumes the caller qualifies the result with the request strobe.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int N_W    = NWORDS
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-3:0] idx,
    output logic              hit
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_W - 1);

    // combine alignment and range into one accept flag
    always_comb begin
        idx = addr[ADDR_W-1:2];
        hit = (addr[1:0] == 2'b00) && (idx <= LAST);
    end

endmodule

// File: rtl/sysctl_word.sv
// One 32-bit storage word that applies its write rule (overwrite, ignore,
// clear-where-one, set-only) and loads rst_val during synchronous reset.
// Assumes wr_en is already qualified by a valid, aligned, in-range write.
module sysctl_word
    import sysctl_pkg::*;
#(
    parameter acc_e KIND = ACC_RW,
    parameter int   W    = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] nxt;

    // value the word would take on a write under its rule
    always_comb begin
        case (KIND)
            ACC_RO:  nxt = q;
            ACC_W1C: nxt = q & ~wdata;
            ACC_SET: nxt = q | wdata;
            default: nxt = wdata;
        endcase
    end

    // storage with cold load
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= rst_val;
        else if (wr_en) q <= nxt;
    end

    if (KIND == ACC_RO) begin : g_chk_ro
        p_ro_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> $stable(q));
    end else if (KIND == ACC_W1C) begin : g_chk_w1c
        p_w1c_noset_r4: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((q & ~$past(q)) == '0));
    end else if (KIND == ACC_SET) begin : g_chk_set
        p_set_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (($past(q) & ~q) == '0));
    end

endmodule

// File: rtl/sysctl_rdport.sv
// Registered read port: selects the addressed word and returns it with a
// response strobe one cycle after a read request; zero when rejected.
// Assumes rd_req is a qualified read strobe and hit flags a legal word.
module sysctl_rdport
    import sysctl_pkg::*;
#(
    parameter int N_W   = NWORDS,
    parameter int W     = DW,
    parameter int IDX_W = IW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_req,
    input  logic                  hit,
    input  logic [IDX_W-1:0]      idx,
    input  logic [N_W-1:0][W-1:0] words,
    output logic                  rsp_valid,
    output logic [W-1:0]          rsp_rdata
);

    logic [W-1:0] sel;

    // one-hot compare mux over the implemented words
    always_comb begin
        sel = '0;
        for (int i = 0; i < N_W; i++) begin
            if (idx == IDX_W'(i)) sel = words[i];
        end
    end

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_rdata <= (rd_req && hit) ? sel : '0;
        end
    end

    p_rsp_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
    p_rsp_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);

endmodule

// File: rtl/sysctl_regbank.sv
// System control register bank top: decodes requests, instantiates one
// word per implemented index with its rule and cold value, and returns
// registered read data. Assumes a single request per cycle.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter logic [2:0] MEM_SIZE_CODE = 3'd2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] strap_pwron,
    input  logic [DW-1:0] strap_moddis,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);

    localparam logic [DW-1:0] MEMCFG_RST =
        MEMCFG_BASE | (DW'(MEM_SIZE_CODE) << 8);
    localparam logic [AW-1:0] FIRST_OOB = AW'(NWORDS * 4);

    if (MEM_SIZE_CODE > 3'd4) begin : g_bad_size
        $error("sysctl_regbank: MEM_SIZE_CODE above 4 is not supported");
    end

    logic [IW-1:0]             idx;
    logic                      hit;
    logic                      wr_ok;
    logic                      rd_req;
    logic [NWORDS-1:0][DW-1:0] words;

    sysctl_decode #(.ADDR_W(AW), .N_W(NWORDS)) u_dec (
        .addr (req_addr),
        .idx  (idx),
        .hit  (hit)
    );

    // qualify strobes for the write path and the read port
    always_comb begin
        wr_ok  = req_valid && req_write && hit;
        rd_req = req_valid && !req_write;
    end

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        logic [DW-1:0] rv;
        if (i == IDX_STRAP) begin : g_rv
            assign rv = strap_pwron;
        end else if (i == IDX_MODDIS) begin : g_rv
            assign rv = strap_moddis;
        end else if (i == IDX_MEMCFG) begin : g_rv
            assign rv = MEMCFG_RST;
        end else begin : g_rv
            assign rv = fixed_rst(i);
        end

        sysctl_word #(.KIND(acc_of(i)), .W(DW)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .rst_val (rv),
            .wr_en   (wr_ok && (idx == IW'(i))),
            .wdata   (req_wdata),
            .q       (words[i])
        );
    end

    sysctl_rdport #(.N_W(NWORDS), .W(DW), .IDX_W(IW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .hit       (hit),
        .idx       (idx),
        .words     (words),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    p_reject_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (req_addr >= FIRST_OOB)) |=> (rsp_rdata == '0));
    p_misalign_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (req_addr[1:0] != 2'b00)) |=> (rsp_rdata == '0));

endmodule

// File: tb/sysctl_regbank_test.sv
// Scoreboard bench: driver tasks push expected read data, a monitor pops
// and compares on each response strobe.
module sysctl_regbank_test;

    localparam int NW = 82;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] strap_pwron = '0;
    logic [31:0] strap_moddis = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [NW];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    sysctl_regbank #(.MEM_SIZE_CODE(3'd2)) uut (
        .clk(clk), .rst_n(rst_n),
        .strap_pwron(strap_pwron), .strap_moddis(strap_moddis),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // cold values from R1 and R2
    function automatic logic [31:0] cold(input int i);
        case (i)
            0:  return 32'h04A92750;
            1:  return strap_pwron;
            6:  return 32'h0000FFFF;
            14: return 32'h00000003;
            15: return 32'h0000035E;
            20: return 32'h0000004E;
            24: return 32'h00080000;
            27: return 32'h80000000;
            30: return 32'h000000C0;
            31: return strap_moddis;
            38: return 32'h5A00F3CF;
            39: return 32'h00001202;
            79: return 32'h00000008;
            80: return 32'h034730E4;
            81: return 32'h034730E4;
            default: return 32'h0;
        endcase
    endfunction

    task automatic do_reset(input logic [31:0] pw, input logic [31:0] md);
        @(negedge clk);
        rst_n = 1'b0; strap_pwron = pw; strap_moddis = md;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NW; i++) mdl[i] = cold(i);
    endtask

    // one-cycle write; model follows R3..R8
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        int i;
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        i = int'(a[11:2]);
        if (a[1:0] == 2'b00 && i < NW) begin
            case (i)
                0, 1, 16: ;
                27, 53:   mdl[i] = mdl[i] & ~d;
                28, 31:   mdl[i] = mdl[i] | d;
                default:  mdl[i] = d;
            endcase
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // one-cycle read; expected value pushed to the scoreboard
    task automatic rd(input logic [11:0] a, input string tag);
        int i;
        i = int'(a[11:2]);
        exp_q.push_back((a[1:0] == 2'b00 && i < NW) ? mdl[i] : 32'h0);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: compare each response with the oldest expected item (R9)
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected response act=%h exp=none", rsp_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    errors++;
                    $display("FAIL %s addr-read act=%h exp=%h", t, rsp_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // reset state: every word, R1 and R2
        do_reset(32'hA5A5_1234, 32'h0000_0F0F);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_rdata !== 32'h0) begin
            errors++;
            $display("FAIL R9 reset outputs act=%b/%h exp=0/0", rsp_valid, rsp_rdata);
        end
        for (int i = 0; i < NW; i++) rd(12'(i * 4), "R1/R2 cold");

        // R3 read-only words
        wr(12'h000, 32'hFFFF_FFFF); wr(12'h004, 32'h0); wr(12'h040, 32'hFFFF_FFFF);
        rd(12'h000, "R3 id"); rd(12'h004, "R3 strap"); rd(12'h040, "R3 status");

        // R4 clear-where-one
        wr(12'h06C, 32'h0000_0000); rd(12'h06C, "R4 zero write");
        wr(12'h06C, 32'h8000_0000); rd(12'h06C, "R4 clear");
        wr(12'h0D4, 32'hFFFF_0000); rd(12'h0D4, "R4 no set");

        // R5 set-only
        wr(12'h070, 32'h0000_000F); wr(12'h070, 32'h0000_00F0);
        rd(12'h070, "R5 accumulate");
        wr(12'h070, 32'h0); rd(12'h070, "R5 no clear");
        wr(12'h07C, 32'h0000_F000); rd(12'h07C, "R5 mask");

        // R6 overwrite, R9 read right after write
        wr(12'h080, 32'hDEAD_BEEF); rd(12'h080, "R6/R9 back-to-back");
        wr(12'h018, 32'h0000_1234); rd(12'h018, "R6 overwrite");
        wr(12'h144, 32'h0BAD_F00D); rd(12'h144, "R6 last word");
        wr(12'h09C, 32'h0); rd(12'h09C, "R6 memcfg writable");

        // R7 out of range
        wr(12'h148, 32'h1111_1111); rd(12'h148, "R7 read past end");
        rd(12'h144, "R7 last word untouched"); rd(12'hFFC, "R7 top of window");
        wr(12'hFFC, 32'h2222_2222); rd(12'h000, "R7 no alias at zero");

        // R8 misaligned
        wr(12'h082, 32'h5555_5555); rd(12'h080, "R8 word below untouched");
        rd(12'h081, "R8 read misaligned"); rd(12'h083, "R8 read misaligned hi");

        // second cold reset with other straps, R2 and R5 reset clear
        do_reset(32'h0000_00FF, 32'h8000_0001);
        rd(12'h004, "R2 strap reload"); rd(12'h07C, "R2 moddis reload");
        rd(12'h070, "R5 reset clears"); rd(12'h09C, "R2 memcfg code");
        rd(12'h06C, "R1 status reload"); rd(12'h080, "R1 plain cleared");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9 missing responses act=%0d exp=0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule